// File: doc/BRIEF.md
# Flash Controller Interrupt Status and Enable Unit

This block sits beside the transfer engine of a serial flash controller and turns the engine's single-cycle word-complete pulse into a level interrupt for the host. It keeps a raw status vector, which records each event whether or not it is enabled, and an enable mask. The host sees the AND of the two as a masked status, and the interrupt line is high while any masked bit is set.

The enable mask has no direct write path. The host turns an enable on through one address and off through another, writing ones only in the bits it wants to change, so that two agents cannot overwrite each other's enables. A pending event is acknowledged by writing a one to its bit at the masked status address. Writing ones at the raw status address injects an event, so that software can test its handler. The word-complete source occupies bit 1. The other bits of the 32-bit word are reserved: they read zero and ignore writes.

The bus port is a plain register port: one write strobe, one read strobe, a byte address and 32-bit data. Read data is registered and is valid in the cycle after the read strobe.

Top module: `flash_irq_ctrl`

## Requirements
- R1: After reset, the raw status, the enable mask, the interrupt output and the read data are all zero.
- R2: A high level on the event input at a clock edge sets raw status bit 1 on that edge whether or not the event is enabled, and the bit stays set until the host clears it.
- R3: A read strobe at offset 0x20 returns the raw status vector on the read data in the cycle after the strobe.
- R4: A read at offset 0x24 returns raw status AND enable mask, so it returns zero when no enabled event is pending.
- R5: Writing a 1 to bit 1 at offset 0x28 sets enable bit 1; zero bits in that write leave the mask unchanged.
- R6: Writing a 1 to bit 1 at offset 0x2C clears enable bit 1; zero bits in that write leave the mask unchanged.
- R7: A read at offset 0x28 or at offset 0x2C returns the current enable mask.
- R8: Writing a 1 to bit 1 at offset 0x24 clears raw status bit 1; zero bits in that write leave the status unchanged.
- R9: When an event and a clear write of the same bit fall on the same clock edge, the status bit is set after that edge.
- R10: Writing a 1 to bit 1 at offset 0x20 sets raw status bit 1 (test injection); zero bits in that write leave the status unchanged.
- R11: The interrupt output is a registered level that is high exactly when raw status AND enable mask is nonzero, and it changes on the same edge as the state that drives it.
- R12: Bits other than bit 1 read zero at every offset and ignore writes, and any address outside the four offsets reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wc_evt_i | input | 1 | Single-cycle word-complete event from the transfer engine |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The assertions take for granted that the write and read strobes are never high together and that a set write and a clear write of the enable mask cannot land on the same edge, because they use distinct addresses on a single port. They also expect the event input to be driven only at known levels once reset is released. The directed stimulus issues one bus operation per strobe cycle, lines up an event with a status clear only in the collision scenario, and drives every input half a cycle away from the sampling edge.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

   // Byte offsets of the register window; the host software decodes these.
   localparam logic [31:0] OFS_RAW    = 32'h20;
   localparam logic [31:0] OFS_MASKED = 32'h24;
   localparam logic [31:0] OFS_EN_SET = 32'h28;
   localparam logic [31:0] OFS_EN_CLR = 32'h2C;

   typedef enum logic [2:0] {
      SEL_NONE   = 3'd0,
      SEL_RAW    = 3'd1,
      SEL_MASKED = 3'd2,
      SEL_EN_SET = 3'd3,
      SEL_EN_CLR = 3'd4
   } reg_sel_e;

endpackage

// File: rtl/flash_irq_decode.sv
module flash_irq_decode
   import flash_irq_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);

   localparam logic [ADDR_W-1:0] RAW_A    = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] MASKED_A = ADDR_W'(OFS_MASKED);
   localparam logic [ADDR_W-1:0] EN_SET_A = ADDR_W'(OFS_EN_SET);
   localparam logic [ADDR_W-1:0] EN_CLR_A = ADDR_W'(OFS_EN_CLR);

   generate
      if (ADDR_W < 6) begin : g_addr_chk
         $error("flash_irq_decode: ADDR_W must reach offset 0x2C");
      end
   endgenerate

   logic [ADDR_W-1:0] word_addr;

   always_comb begin
      word_addr = {addr_i[ADDR_W-1:2], 2'b00};
      if (word_addr == RAW_A)          sel_o = SEL_RAW;
      else if (word_addr == MASKED_A)  sel_o = SEL_MASKED;
      else if (word_addr == EN_SET_A)  sel_o = SEL_EN_SET;
      else if (word_addr == EN_CLR_A)  sel_o = SEL_EN_CLR;
      else                             sel_o = SEL_NONE;
   end

endmodule

// File: rtl/flash_irq_bit_cell.sv
module flash_irq_bit_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic inject_i,
   input  logic ack_i,
   input  logic en_set_i,
   input  logic en_clr_i,
   output logic raw_o,
   output logic en_o
);

   logic raw_q;
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         // event and injection win over an acknowledge on the same edge
         raw_q <= (raw_q & ~ack_i) | evt_i | inject_i;
         en_q  <= (en_q & ~en_clr_i) | en_set_i;
      end
   end

   assign raw_o = raw_q;
   assign en_o  = en_q;

   // R2
   evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> raw_o);
   // R2
   raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_o && !ack_i) |=> raw_o);
   // R8
   raw_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !evt_i && !inject_i) |=> !raw_o);
   // R5
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_set_i |=> en_o);
   // R6
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_clr_i && !en_set_i) |=> !en_o);

endmodule

// File: rtl/flash_irq_read_mux.sv
module flash_irq_read_mux
   import flash_irq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  reg_sel_e          sel_i,
   input  logic [DATA_W-1:0] raw_i,
   input  logic [DATA_W-1:0] en_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] rd_val;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      unique case (sel_i)
         SEL_RAW:                rd_val = raw_i;
         SEL_MASKED:             rd_val = raw_i & en_i;
         SEL_EN_SET, SEL_EN_CLR: rd_val = en_i;
         default:                rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    rdata_q <= '0;
      else if (rd_i) rdata_q <= rd_val;
   end

   assign rdata_o = rdata_q;

   // R12
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && sel_i == SEL_NONE) |=> (rdata_o == '0));
   // R3
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
   import flash_irq_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter int          ADDR_W   = 8,
   parameter int          WC_BIT   = 1,
   parameter logic [31:0] IMPL_MSK = 32'h0000_0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wc_evt_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);

   localparam logic [DATA_W-1:0] IMPL = DATA_W'(IMPL_MSK);

   generate
      if (DATA_W < 2 || DATA_W > 32) begin : g_width_chk
         $error("flash_irq_ctrl: DATA_W out of range");
      end
      if (WC_BIT < 0 || WC_BIT >= DATA_W) begin : g_bit_chk
         $error("flash_irq_ctrl: WC_BIT outside the data word");
      end
      if (IMPL_MSK[WC_BIT] == 1'b0) begin : g_impl_chk
         $error("flash_irq_ctrl: word-complete bit not implemented");
      end
   endgenerate

   reg_sel_e          sel;
   logic [DATA_W-1:0] evt_vec;
   logic [DATA_W-1:0] inject_vec;
   logic [DATA_W-1:0] ack_vec;
   logic [DATA_W-1:0] en_set_vec;
   logic [DATA_W-1:0] en_clr_vec;
   logic [DATA_W-1:0] raw_vec;
   logic [DATA_W-1:0] en_vec;
   logic [DATA_W-1:0] raw_nxt;
   logic [DATA_W-1:0] en_nxt;
   logic              irq_q;

   flash_irq_decode #(.ADDR_W(ADDR_W)) decode_i (
      .addr_i (bus_addr_i),
      .sel_o  (sel)
   );

   always_comb begin
      evt_vec         = '0;
      evt_vec[WC_BIT] = wc_evt_i;
      inject_vec = (bus_wr_i && sel == SEL_RAW)    ? bus_wdata_i : '0;
      ack_vec    = (bus_wr_i && sel == SEL_MASKED) ? bus_wdata_i : '0;
      en_set_vec = (bus_wr_i && sel == SEL_EN_SET) ? bus_wdata_i : '0;
      en_clr_vec = (bus_wr_i && sel == SEL_EN_CLR) ? bus_wdata_i : '0;
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (IMPL[b]) begin : g_cell
         flash_irq_bit_cell cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_vec[b]),
            .inject_i (inject_vec[b]),
            .ack_i    (ack_vec[b]),
            .en_set_i (en_set_vec[b]),
            .en_clr_i (en_clr_vec[b]),
            .raw_o    (raw_vec[b]),
            .en_o     (en_vec[b])
         );
      end else begin : g_tie
         assign raw_vec[b] = 1'b0;
         assign en_vec[b]  = 1'b0;
      end
   end

   // next-state view so the interrupt register moves on the same edge
   always_comb begin
      raw_nxt = ((raw_vec & ~ack_vec) | evt_vec | inject_vec) & IMPL;
      en_nxt  = ((en_vec & ~en_clr_vec) | en_set_vec) & IMPL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(raw_nxt & en_nxt);
   end

   assign irq_o = irq_q;

   flash_irq_read_mux #(.DATA_W(DATA_W)) rmux_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_i    (bus_rd_i),
      .sel_i   (sel),
      .raw_i   (raw_vec),
      .en_i    (en_vec),
      .rdata_o (bus_rdata_o)
   );

   // R11
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (|(raw_vec & en_vec)));
   // R12
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_vec | en_vec) & ~IMPL) == '0);
   // R9
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wc_evt_i && bus_wr_i && sel == SEL_MASKED) |=> raw_vec[WC_BIT]);

endmodule

// File: tb/flash_irq_ctrl_tb.sv
module flash_irq_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wc_evt_i = 1'b0;
   logic        bus_wr_i = 1'b0;
   logic        bus_rd_i = 1'b0;
   logic [7:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   flash_irq_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wc_evt_i    (wc_evt_i),
      .bus_wr_i    (bus_wr_i),
      .bus_rd_i    (bus_rd_i),
      .bus_addr_i  (bus_addr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .irq_o       (irq_o)
   );

   localparam logic [7:0] A_RAW = 8'h20, A_MSK = 8'h24, A_SET = 8'h28, A_CLR = 8'h2C;

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   // inputs change on the falling edge; results sampled on the next falling edge
   task automatic bus_write(logic [7:0] a, logic [31:0] d, bit with_evt = 0);
      @(negedge clk);
      bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d; wc_evt_i = with_evt;
      @(negedge clk);
      bus_wr_i = 1'b0; wc_evt_i = 1'b0;
   endtask

   task automatic bus_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd_i = 1'b1; bus_addr_i = a;
      @(negedge clk);
      bus_rd_i = 1'b0;
      d = bus_rdata_o;
   endtask

   task automatic pulse_evt();
      @(negedge clk);
      wc_evt_i = 1'b1;
      @(negedge clk);
      wc_evt_i = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 irq", {31'd0, irq_o}, 32'd0);
      check("R1 rdata", bus_rdata_o, 32'd0);
      bus_read(A_RAW, d); check("R1 raw", d, 32'd0);
      bus_read(A_SET, d); check("R1 enable", d, 32'd0);
   endtask

   task automatic t_event_disabled();
      logic [31:0] d;
      pulse_evt();
      check("R11 irq while disabled", {31'd0, irq_o}, 32'd0);
      repeat (3) @(negedge clk);
      bus_read(A_RAW, d); check("R2 R3 raw latched", d, 32'h2);
      bus_read(A_MSK, d); check("R4 masked zero when disabled", d, 32'd0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      bus_write(A_SET, 32'h0);
      bus_read(A_SET, d); check("R5 zero write no effect", d, 32'd0);
      bus_write(A_SET, 32'h2);
      check("R11 irq on enable", {31'd0, irq_o}, 32'd1);
      bus_read(A_SET, d); check("R7 read at set", d, 32'h2);
      bus_read(A_CLR, d); check("R7 read at clear", d, 32'h2);
      bus_read(A_MSK, d); check("R4 masked pending", d, 32'h2);
   endtask

   task automatic t_ack();
      logic [31:0] d;
      bus_write(A_MSK, 32'hFFFF_FFFD);
      bus_read(A_RAW, d); check("R8 zero bit no clear", d, 32'h2);
      check("R11 irq still high", {31'd0, irq_o}, 32'd1);
      bus_write(A_MSK, 32'h2);
      check("R11 irq drops on ack", {31'd0, irq_o}, 32'd0);
      bus_read(A_RAW, d); check("R8 cleared", d, 32'd0);
   endtask

   task automatic t_collision();
      logic [31:0] d;
      bus_write(A_MSK, 32'h2, 1);
      check("R9 irq after collision", {31'd0, irq_o}, 32'd1);
      bus_read(A_RAW, d); check("R9 event wins", d, 32'h2);
   endtask

   task automatic t_disable();
      logic [31:0] d;
      bus_write(A_CLR, 32'hFFFF_FFFD);
      bus_read(A_CLR, d); check("R6 zero bit no disable", d, 32'h2);
      bus_write(A_CLR, 32'h2);
      check("R11 irq off when disabled", {31'd0, irq_o}, 32'd0);
      bus_read(A_SET, d); check("R6 disabled", d, 32'd0);
      bus_read(A_RAW, d); check("R2 raw kept while disabled", d, 32'h2);
   endtask

   task automatic t_inject();
      logic [31:0] d;
      bus_write(A_MSK, 32'h2);
      bus_write(A_RAW, 32'hFFFF_FFFD);
      bus_read(A_RAW, d); check("R10 zero bit no inject", d, 32'd0);
      bus_write(A_RAW, 32'hFFFF_FFFF);
      bus_read(A_RAW, d); check("R10 R12 inject bit 1 only", d, 32'h2);
      bus_write(A_SET, 32'hFFFF_FFFF);
      bus_read(A_SET, d); check("R12 reserved enables", d, 32'h2);
      check("R11 irq from injected", {31'd0, irq_o}, 32'd1);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      bus_write(8'h30, 32'hFFFF_FFFF);
      bus_write(8'h00, 32'hFFFF_FFFF);
      bus_read(8'h30, d); check("R12 unmapped read", d, 32'd0);
      bus_read(A_SET, d); check("R12 enable untouched", d, 32'h2);
      bus_read(A_RAW, d); check("R12 raw untouched", d, 32'h2);
      bus_write(A_MSK, 32'h2);
      bus_read(8'h30, d); check("R12 unmapped read after clear", d, 32'd0);
      bus_read(A_RAW, d); check("R8 cleared again", d, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_event_disabled();
      t_enable();
      t_ack();
      t_collision();
      t_disable();
      t_inject();
      t_unmapped();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule